// File: doc/BRIEF.md
# Local Processor Interrupt Arbiter

This block sits beside one processor core and takes in interrupt messages sent to that core. It decides which interrupt the core should take next. Each message carries an 8-bit vector, a delivery mode, a trigger flag, an addressing flag and a destination field. Messages not meant for this core are dropped.

Ordinary vectors, in fixed or lowest-priority mode, are queued in three 256-bit arrays: requested, in service, and level-triggered. They are gated by the core's interrupt-enable flag, by the task-priority class and by the vector last put in service.

System-management, non-maskable, init and external events are each held in a single pending flag, together with the vector of the first message that set it. System-management, non-maskable and init events are presented even while interrupts are disabled. The block presents one winner at a time, as a kind and a vector. A one-cycle acknowledge strobe retires that winner.

Top module: `core_irq_arbiter`

## Requirements
- R1: A message is accepted only if one of two conditions holds. With `msg_logical`=0, `msg_dest` must equal `local_id`. With `msg_logical`=1, `local_id` must be below 8 and bit `local_id` of `msg_dest` must be 1. All other messages change nothing.
- R2: Delivery modes are encoded as 0 fixed, 1 lowest-priority, 2 system-management, 4 non-maskable, 5 init and 7 external. Modes 3 and 6 are reserved and have no effect.
- R3: A fixed or lowest-priority message sets the request bit of its vector. If that bit is already set, the message changes nothing, including the trigger flag.
- R4: When a request bit is newly set, the level flag of that vector is recorded from `msg_level`. `irq_level` shows the recorded flag while kind 5 is presented, and is 0 otherwise.
- R5: Among requested vectors, the highest numbered one is the one presented.
- R6: A requested vector is pending only if all three hold: `int_enable` is 1, the vector is above the in-service vector, and its bits 7:4 exceed bits 7:4 of `task_prio`.
- R7: System-management, non-maskable and init events are pending whatever `int_enable` is. A repeat message of the same kind is ignored while its flag is set, so the first saved vector is kept.
- R8: A pending external event is presented only while `int_enable` is 1.
- R9: The winner is chosen in this order: system-management (kind 1), non-maskable (kind 2), init (kind 3), external (kind 4), requested vector (kind 5). The kind is 0 and the vector is 0 when nothing is pending.
- R10: Acknowledging a system-management, non-maskable or init event clears only that event's flag. Any other pending events stay pending.
- R11: Acknowledging a requested vector makes it the in-service vector and removes its request. The next highest request is then presented if it still passes R6.
- R12: When an acknowledge and a message arrive in the same cycle, the acknowledge is applied first, to the winner presented before the message.
- R13: After reset nothing is pending: `irq_pending`=0, kind 0, vector 0.
- R14: An acknowledge while `irq_pending` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_id | input | 8 | Identity of this core |
| msg_valid | input | 1 | One-cycle strobe: a message is present |
| msg_vector | input | 8 | Message vector |
| msg_mode | input | 3 | Delivery mode (R2) |
| msg_level | input | 1 | 1 level-triggered, 0 edge-triggered |
| msg_logical | input | 1 | Addressing flag (R1) |
| msg_dest | input | 8 | Destination field |
| int_enable | input | 1 | Core interrupt-enable flag |
| task_prio | input | 8 | Task-priority value |
| ack | input | 1 | One-cycle strobe: the presented interrupt is taken |
| irq_pending | output | 1 | An interrupt is ready for the core |
| irq_kind | output | 3 | Kind of the winner (R9) |
| irq_vector | output | 8 | Vector of the winner |
| irq_level | output | 1 | Level flag of a presented requested vector |

## Verification
Retirement and message intake can fall in the same cycle. The bench provokes this by raising `ack` while a requested vector 0x80 is presented and, on the same edge, sending vector 0x90. It passes only if 0x80 goes into service and 0x90 is then shown. If the message were applied first, 0x90 would be retired and nothing would be shown.

A second case sends a system-management message together with an acknowledge of a requested vector. The requested vector must be retired, and the new event must become the winner.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;

    localparam logic [2:0] MODE_FIXED  = 3'd0;
    localparam logic [2:0] MODE_LOWEST = 3'd1;
    localparam logic [2:0] MODE_SMI    = 3'd2;
    localparam logic [2:0] MODE_NMI    = 3'd4;
    localparam logic [2:0] MODE_INIT   = 3'd5;
    localparam logic [2:0] MODE_EXT    = 3'd7;

    typedef enum logic [2:0] {
        KIND_NONE  = 3'd0,
        KIND_SMI   = 3'd1,
        KIND_NMI   = 3'd2,
        KIND_INIT  = 3'd3,
        KIND_EXT   = 3'd4,
        KIND_FIXED = 3'd5
    } irq_kind_e;

    typedef struct packed {
        logic hit;
        logic normal;
        logic smi;
        logic nmi;
        logic init;
        logic ext;
    } msg_class_t;

endpackage

// File: rtl/irq_msg_decode.sv
`timescale 1ns/1ps
module irq_msg_decode
    import irq_arb_pkg::*;
#(
    parameter int DEST_W = 8
) (
    input  logic              valid,
    input  logic [2:0]        mode,
    input  logic              logical,
    input  logic [DEST_W-1:0] dest,
    input  logic [DEST_W-1:0] local_id,
    output msg_class_t        cls
);
    localparam int IDX_W = $clog2(DEST_W);

    logic phys_hit;
    logic logi_hit;
    logic hit;

    always_comb begin
        phys_hit = !logical && (dest == local_id);
        logi_hit = logical && ((local_id >> IDX_W) == '0) && dest[local_id[IDX_W-1:0]];
        hit      = valid && (phys_hit || logi_hit);

        cls        = '0;
        cls.hit    = hit;
        cls.normal = hit && (mode == MODE_FIXED || mode == MODE_LOWEST);
        cls.smi    = hit && (mode == MODE_SMI);
        cls.nmi    = hit && (mode == MODE_NMI);
        cls.init   = hit && (mode == MODE_INIT);
        cls.ext    = hit && (mode == MODE_EXT);
    end
endmodule

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc #(
    parameter int N = 256,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic [W-1:0] idx
);
    // Highest set bit wins; an empty input yields index 0.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/core_irq_arbiter.sv
`timescale 1ns/1ps
module core_irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int DEST_W = 8,
    parameter int CLS_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEST_W-1:0] local_id,
    input  logic              msg_valid,
    input  logic [VEC_W-1:0]  msg_vector,
    input  logic [2:0]        msg_mode,
    input  logic              msg_level,
    input  logic              msg_logical,
    input  logic [DEST_W-1:0] msg_dest,
    input  logic              int_enable,
    input  logic [VEC_W-1:0]  task_prio,
    input  logic              ack,
    output logic              irq_pending,
    output logic [2:0]        irq_kind,
    output logic [VEC_W-1:0]  irq_vector,
    output logic              irq_level
);
    localparam int NVEC = 1 << VEC_W;

    typedef struct packed {
        logic [NVEC-1:0]  irr;
        logic [NVEC-1:0]  isr;
        logic [NVEC-1:0]  tmr;
        logic [VEC_W-1:0] irrv;
        logic [VEC_W-1:0] isrv;
        logic             smi;
        logic             nmi;
        logic             init;
        logic             ext;
        logic             unmask;
        logic [VEC_W-1:0] smi_vec;
        logic [VEC_W-1:0] nmi_vec;
        logic [VEC_W-1:0] init_vec;
        logic [VEC_W-1:0] ext_vec;
    } state_t;

    state_t     state_q, state_d;
    msg_class_t mcls;
    irq_kind_e  win;
    logic       norm_ready;
    logic       take;
    logic [NVEC-1:0]  irr_ack;
    logic [VEC_W-1:0] top_vec;

    irq_msg_decode #(.DEST_W(DEST_W)) u_decode (
        .valid    (msg_valid),
        .mode     (msg_mode),
        .logical  (msg_logical),
        .dest     (msg_dest),
        .local_id (local_id),
        .cls      (mcls)
    );

    // Winner selection from registered state and live core inputs.
    always_comb begin
        norm_ready = int_enable && (state_q.irrv > state_q.isrv) &&
                     (state_q.irrv[VEC_W-1 -: CLS_W] > task_prio[VEC_W-1 -: CLS_W]);
        win        = KIND_NONE;
        irq_vector = '0;
        if (state_q.unmask) begin
            if (state_q.smi) begin
                win = KIND_SMI;   irq_vector = state_q.smi_vec;
            end else if (state_q.nmi) begin
                win = KIND_NMI;   irq_vector = state_q.nmi_vec;
            end else if (state_q.init) begin
                win = KIND_INIT;  irq_vector = state_q.init_vec;
            end
        end else if (int_enable && state_q.ext) begin
            win = KIND_EXT;       irq_vector = state_q.ext_vec;
        end else if (norm_ready) begin
            win = KIND_FIXED;     irq_vector = state_q.irrv;
        end
        irq_pending = (win != KIND_NONE);
        irq_kind    = win;
        irq_level   = (win == KIND_FIXED) ? state_q.tmr[state_q.irrv] : 1'b0;
        take        = ack && irq_pending;
    end

    // Request array after the acknowledge, fed to the encoder.
    always_comb begin
        irr_ack = state_q.irr;
        if (take && win == KIND_FIXED) irr_ack[state_q.irrv] = 1'b0;
    end

    irq_prio_enc #(.N(NVEC), .W(VEC_W)) u_enc (
        .req (irr_ack),
        .idx (top_vec)
    );

    // Next state: acknowledge first, then the incoming message.
    always_comb begin
        state_d      = state_q;
        state_d.irr  = irr_ack;
        state_d.irrv = top_vec;
        if (take) begin
            case (win)
                KIND_SMI:   state_d.smi  = 1'b0;
                KIND_NMI:   state_d.nmi  = 1'b0;
                KIND_INIT:  state_d.init = 1'b0;
                KIND_EXT:   state_d.ext  = 1'b0;
                KIND_FIXED: begin
                    state_d.isrv                = state_q.irrv;
                    state_d.isr[state_q.irrv]   = 1'b1;
                end
                default: ;
            endcase
            if (!(state_d.smi || state_d.nmi || state_d.init)) state_d.unmask = 1'b0;
        end
        if (mcls.normal) begin
            if (msg_vector > state_d.irrv) state_d.irrv = msg_vector;
            if (!state_d.irr[msg_vector]) begin
                state_d.irr[msg_vector] = 1'b1;
                state_d.tmr[msg_vector] = msg_level;
            end
        end
        if (mcls.smi && !state_d.smi) begin
            state_d.smi = 1'b1;  state_d.smi_vec = msg_vector;  state_d.unmask = 1'b1;
        end
        if (mcls.nmi && !state_d.nmi) begin
            state_d.nmi = 1'b1;  state_d.nmi_vec = msg_vector;  state_d.unmask = 1'b1;
        end
        if (mcls.init && !state_d.init) begin
            state_d.init = 1'b1; state_d.init_vec = msg_vector; state_d.unmask = 1'b1;
        end
        if (mcls.ext && !state_d.ext) begin
            state_d.ext = 1'b1;  state_d.ext_vec = msg_vector;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/irq_arb_chk.sv
`timescale 1ns/1ps
module irq_arb_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             msg_valid,
    input logic [2:0]       msg_mode,
    input logic             int_enable,
    input logic [VEC_W-1:0] task_prio,
    input logic             irq_pending,
    input logic [2:0]       irq_kind,
    input logic [VEC_W-1:0] irq_vector,
    input logic             smi,
    input logic             nmi,
    input logic             init,
    input logic             unmask,
    input logic [VEC_W-1:0] isrv
);
    // R7
    unmask_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmask == (smi || nmi || init));

    // R7
    unmask_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smi || nmi || init) |-> irq_pending);

    // R8
    masked_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && !int_enable) |-> (irq_kind inside {3'd1, 3'd2, 3'd3}));

    // R6
    class_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_kind == 3'd5) |-> (irq_vector[VEC_W-1 -: 4] > task_prio[VEC_W-1 -: 4]));

    // R11
    isr_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_kind == 3'd5) |=> (isrv == $past(irq_vector)));

    // R10
    smi_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_kind == 3'd1 && !(msg_valid && msg_mode == 3'd2)) |=> !smi);

    // R9
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pending |-> (irq_kind == 3'd0 && irq_vector == '0));
endmodule

bind core_irq_arbiter irq_arb_chk #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack         (ack),
    .msg_valid   (msg_valid),
    .msg_mode    (msg_mode),
    .int_enable  (int_enable),
    .task_prio   (task_prio),
    .irq_pending (irq_pending),
    .irq_kind    (irq_kind),
    .irq_vector  (irq_vector),
    .smi         (state_q.smi),
    .nmi         (state_q.nmi),
    .init        (state_q.init),
    .unmask      (state_q.unmask),
    .isrv        (state_q.isrv)
);

// File: tb/tb_core_irq_arbiter.sv
`timescale 1ns/1ps
module tb_core_irq_arbiter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] local_id;
    logic       msg_valid;
    logic [7:0] msg_vector;
    logic [2:0] msg_mode;
    logic       msg_level;
    logic       msg_logical;
    logic [7:0] msg_dest;
    logic       int_enable;
    logic [7:0] task_prio;
    logic       ack;
    logic       irq_pending;
    logic [2:0] irq_kind;
    logic [7:0] irq_vector;
    logic       irq_level;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    core_irq_arbiter dut (
        .clk(clk), .rst_n(rst_n), .local_id(local_id),
        .msg_valid(msg_valid), .msg_vector(msg_vector), .msg_mode(msg_mode),
        .msg_level(msg_level), .msg_logical(msg_logical), .msg_dest(msg_dest),
        .int_enable(int_enable), .task_prio(task_prio), .ack(ack),
        .irq_pending(irq_pending), .irq_kind(irq_kind),
        .irq_vector(irq_vector), .irq_level(irq_level)
    );

    typedef struct packed {
        logic       msg;
        logic [7:0] vec;
        logic [2:0] mode;
        logic       lvl;
        logic       logi;
        logic [7:0] dest;
        logic       ak;
        logic       en;
        logic [7:0] tpr;
        logic       pend;
        logic [2:0] kind;
        logic [7:0] evec;
        logic       elvl;
        logic [7:0] req;
    } step_t;

    localparam int NSTEP = 28;
    // fields: msg vec mode lvl logi dest ack en tpr | pend kind vec lvl | req
    localparam step_t STEPS [NSTEP] = '{
        '{1'b1, 8'h45, 3'd0, 1'b0, 1'b0, 8'h03, 1'b0, 1'b1, 8'h00, 1'b1, 3'd5, 8'h45, 1'b0, 8'd3},  // R3 R1 physical hit
        '{1'b1, 8'h62, 3'd0, 1'b0, 1'b0, 8'h04, 1'b0, 1'b1, 8'h00, 1'b1, 3'd5, 8'h45, 1'b0, 8'd1},  // R1 other core
        '{1'b1, 8'h62, 3'd1, 1'b1, 1'b1, 8'h08, 1'b0, 1'b1, 8'h00, 1'b1, 3'd5, 8'h62, 1'b1, 8'd4},  // R4 R5 logical level
        '{1'b1, 8'h62, 3'd0, 1'b0, 1'b0, 8'h03, 1'b0, 1'b1, 8'h00, 1'b1, 3'd5, 8'h62, 1'b1, 8'd3},  // R3 duplicate keeps level
        '{1'b1, 8'h70, 3'd0, 1'b0, 1'b1, 8'hF7, 1'b0, 1'b1, 8'h00, 1'b1, 3'd5, 8'h62, 1'b1, 8'd1},  // R1 logical miss
        '{1'b1, 8'h90, 3'd3, 1'b0, 1'b0, 8'h03, 1'b0, 1'b1, 8'h00, 1'b1, 3'd5, 8'h62, 1'b1, 8'd2},  // R2 mode 3
        '{1'b1, 8'h91, 3'd6, 1'b0, 1'b0, 8'h03, 1'b0, 1'b1, 8'h00, 1'b1, 3'd5, 8'h62, 1'b1, 8'd2},  // R2 mode 6
        '{1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h62, 1'b0, 3'd0, 8'h00, 1'b0, 8'd6},  // R6 equal class
        '{1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h50, 1'b1, 3'd5, 8'h62, 1'b1, 8'd6},  // R6 class above
        '{1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 8'd6},  // R6 disabled
        '{1'b1, 8'h33, 3'd7, 1'b0, 1'b0, 8'h03, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 8'd8},  // R8 ext masked
        '{1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b1, 3'd4, 8'h33, 1'b0, 8'd9},  // R9 ext over request
        '{1'b1, 8'h02, 3'd4, 1'b0, 1'b0, 8'h03, 1'b0, 1'b0, 8'h00, 1'b1, 3'd2, 8'h02, 1'b0, 8'd7},  // R7 nmi while disabled
        '{1'b1, 8'h00, 3'd5, 1'b0, 1'b0, 8'h03, 1'b0, 1'b0, 8'h00, 1'b1, 3'd2, 8'h02, 1'b0, 8'd9},  // R9 nmi over init
        '{1'b1, 8'h00, 3'd2, 1'b0, 1'b0, 8'h03, 1'b0, 1'b0, 8'h00, 1'b1, 3'd1, 8'h00, 1'b0, 8'd9},  // R9 smi first
        '{1'b1, 8'h07, 3'd4, 1'b0, 1'b0, 8'h03, 1'b0, 1'b0, 8'h00, 1'b1, 3'd1, 8'h00, 1'b0, 8'd7},  // R7 repeat nmi
        '{1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 3'd2, 8'h02, 1'b0, 8'd10}, // R10 smi retired, first nmi vec
        '{1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 3'd3, 8'h00, 1'b0, 8'd10}, // R10 nmi retired
        '{1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 8'd8},  // R8 ext waits
        '{1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b1, 3'd4, 8'h33, 1'b0, 8'd8},  // R8 enabled
        '{1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 1'b1, 3'd5, 8'h62, 1'b1, 8'd9},  // R9 ext retired
        '{1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 8'd11}, // R11 0x45 below service
        '{1'b1, 8'h80, 3'd0, 1'b0, 1'b0, 8'h03, 1'b0, 1'b1, 8'h00, 1'b1, 3'd5, 8'h80, 1'b0, 8'd5},  // R5 new top
        '{1'b1, 8'h90, 3'd0, 1'b0, 1'b0, 8'h03, 1'b1, 1'b1, 8'h00, 1'b1, 3'd5, 8'h90, 1'b0, 8'd12}, // R12 ack before message
        '{1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 8'd11}, // R11 0x90 in service
        '{1'b1, 8'hA0, 3'd0, 1'b0, 1'b0, 8'h03, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 8'd6},  // R6 disabled
        '{1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 8'd14}, // R14 ack while idle
        '{1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b1, 3'd5, 8'hA0, 1'b0, 8'd14}  // R14 still requested
    };

    task automatic check(input int req, input logic ep, input logic [2:0] ek,
                         input logic [7:0] ev, input logic el);
        tests++;
        if (irq_pending !== ep || irq_kind !== ek || irq_vector !== ev || irq_level !== el) begin
            fails++;
            $display("FAIL R%0d: got pend=%0b kind=%0d vec=%02h lvl=%0b, expected pend=%0b kind=%0d vec=%02h lvl=%0b",
                     req, irq_pending, irq_kind, irq_vector, irq_level, ep, ek, ev, el);
        end
    endtask

    task automatic cycle(input logic m, input logic [7:0] v, input logic [2:0] md,
                         input logic lv, input logic lg, input logic [7:0] d,
                         input logic a, input logic e, input logic [7:0] t);
        @(negedge clk);
        msg_valid = m; msg_vector = v; msg_mode = md; msg_level = lv;
        msg_logical = lg; msg_dest = d; ack = a; int_enable = e; task_prio = t;
        @(posedge clk);
        #1;
        msg_valid = 1'b0;
        ack       = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        local_id = 8'h03; msg_valid = 1'b0; msg_vector = '0; msg_mode = '0;
        msg_level = 1'b0; msg_logical = 1'b0; msg_dest = '0;
        int_enable = 1'b1; task_prio = '0; ack = 1'b0;
        do_reset();
        // R13 reset state
        check(13, 1'b0, 3'd0, 8'h00, 1'b0);

        for (int i = 0; i < NSTEP; i++) begin
            cycle(STEPS[i].msg, STEPS[i].vec, STEPS[i].mode, STEPS[i].lvl, STEPS[i].logi,
                  STEPS[i].dest, STEPS[i].ak, STEPS[i].en, STEPS[i].tpr);
            check(int'(STEPS[i].req), STEPS[i].pend, STEPS[i].kind, STEPS[i].evec, STEPS[i].elvl);
        end

        // R13 reset clears a busy state
        do_reset();
        check(13, 1'b0, 3'd0, 8'h00, 1'b0);

        // R1 logical mode with an identity of 8 or more never hits
        local_id = 8'h09;
        cycle(1'b1, 8'h55, 3'd0, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b1, 8'h00);
        check(1, 1'b0, 3'd0, 8'h00, 1'b0);
        cycle(1'b1, 8'h55, 3'd0, 1'b1, 1'b0, 8'h09, 1'b0, 1'b1, 8'h00);
        check(1, 1'b1, 3'd5, 8'h55, 1'b1);

        // R12 smi arrives while the requested vector is acknowledged
        cycle(1'b1, 8'h11, 3'd2, 1'b0, 1'b0, 8'h09, 1'b1, 1'b1, 8'h00);
        check(12, 1'b1, 3'd1, 8'h11, 1'b0);
        cycle(1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00);
        check(12, 1'b0, 3'd0, 8'h00, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule